// File: doc/BRIEF.md
# Integer ALU with Status Flags and Condition Evaluation

This block is the integer execute slice of a simple core. It takes two 32-bit operands and a 3-bit operation code. It returns a result together with a write strobe for the destination. It also keeps a four-bit status register that holds carry, zero, sign and overflow. Five operations are supported: addition, subtraction, comparison, bitwise test, and an address-style addition. These operations differ in two ways: whether the result is written back, and whether the status register is updated.

A separate 4-bit condition code is decoded against the stored status bits. The block drives two outputs from it. The first is a single "take branch" line. The second is a byte that reads 1 or 0 for conditional-set style instructions. Both condition outputs are combinational from the registered flags. A flag-setting operation in one cycle can therefore steer a branch in the next cycle.

Top module: `alu_cond_unit`

## Requirements
- R1: Operation code 0 (add) outputs `opnd_a + opnd_b` modulo 2^32 with `res_we` high, and sets carry when the true sum exceeds 2^32-1. `flag_q` bit order is [3]=carry, [2]=zero, [1]=sign, [0]=overflow.
- R2: For every flag-updating operation, zero is set exactly when the computed value is 0, and sign equals its bit 31.
- R3: For add, overflow is set when both operands share a sign bit and the sum's sign bit differs from it.
- R4: Operation code 1 (subtract) outputs `opnd_a - opnd_b` with `res_we` high. Carry is set when `opnd_a` is below `opnd_b` as unsigned numbers. Overflow is set when the operand signs differ and the difference's sign differs from `opnd_a`'s sign.
- R5: Operation code 2 (compare) updates the flags exactly as subtract does, while holding `res_we` low.
- R6: Operation code 3 (test) holds `res_we` low. It sets zero and sign from `opnd_a & opnd_b`, and clears carry and overflow.
- R7: Operation code 4 (address add) outputs the sum with `res_we` high and leaves all four flags unchanged.
- R8: Flags change only on a rising clock edge where `op_valid` is high and the operation is flag-updating. Codes 5 to 7 neither write a result nor change flags. `res_we` is low whenever `op_valid` is low.
- R9: A low `rst_n` at a rising edge clears all four flags.
- R10: Condition codes, with C, Z, S, O taken from the stored flags, are:
  - 1: Z
  - 2: !Z
  - 3: S
  - 4: !S
  - 5: !(S^O)&!Z
  - 6: !(S^O)
  - 7: S^O
  - 8: (S^O)|Z
  - 9: !C&!Z
  - 10: C
- R11: Condition code 0 is always true, and codes 11 to 15 are always false.
- R12: `set_byte` equals `take_br` in bit 0, with bits 7..1 always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset for the flags |
| op_valid | input | 1 | Operation strobe |
| op_sel | input | 3 | Operation code (0 add, 1 sub, 2 cmp, 3 test, 4 address add) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| res_data | output | 32 | Computed result |
| res_we | output | 1 | Destination write strobe |
| flag_q | output | 4 | Stored flags {carry, zero, sign, overflow} |
| cond_sel | input | 4 | Condition code |
| take_br | output | 1 | Selected condition is true |
| set_byte | output | 8 | Condition as a byte, 0 or 1 |

## Verification
The bench checks the following cases. Each comes with the failure it exposes:

- **Signed overflow in both directions of add, and the subtract-specific overflow cases.** A design that reused the add overflow rule for compare would flag `0x80000000 - 1` wrongly.
- **Borrow on compare of `0x7FFFFFFF` with `0xFFFFFFFF`.** An unsigned "below" built from an inverted carry would disagree with the signed "less" there.
- **A test right after a carry-setting compare.** A design that left carry alone on test would keep a stale carry.
- **Address adds and invalid codes issued while flags are nonzero.** A design that clobbered flags on these would lose the previous flags.
- **A sweep of all sixteen condition codes after every vector.** This catches swapped signed and unsigned predicates, and unused codes that are not false.

// File: rtl/alu_cond_pkg.sv
// Shared types for the integer ALU with flag register and condition unit.
// Assumes a 3-bit operation code and a 4-bit condition code.
package alu_cond_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_CMP = 3'd2,
        OP_TST = 3'd3,
        OP_LEA = 3'd4
    } alu_op_e;

    typedef enum logic [3:0] {
        CC_ALWAYS = 4'd0,
        CC_EQ     = 4'd1,
        CC_NE     = 4'd2,
        CC_NEG    = 4'd3,
        CC_NNEG   = 4'd4,
        CC_SGT    = 4'd5,
        CC_SGE    = 4'd6,
        CC_SLT    = 4'd7,
        CC_SLE    = 4'd8,
        CC_ABOVE  = 4'd9,
        CC_BELOW  = 4'd10
    } cond_e;

    // Stored status bits, packed as {carry, zero, sign, overflow}.
    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic o;
    } flags_t;

endpackage

// File: rtl/alu_arith.sv
// Arithmetic/logic core: computes the result, the candidate flags and
// whether the operation writes a result and/or updates flags.
// Assumes: purely combinational, no gating by the valid strobe.
module alu_arith
    import alu_cond_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2:0]   op_code,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         wr_res,
    output logic         upd_flags,
    output flags_t       nxt
);
    localparam int MSB = W - 1;

    logic [W:0]   sum_x;
    logic [W:0]   dif_x;
    logic [W-1:0] and_v;
    logic         add_ovf;
    logic         sub_ovf;
    alu_op_e      op;

    // Extended-width sum and difference, their carry/borrow and overflows.
    always_comb begin
        op      = alu_op_e'(op_code);
        sum_x   = {1'b0, a} + {1'b0, b};
        dif_x   = {1'b0, a} - {1'b0, b};
        and_v   = a & b;
        add_ovf = (a[MSB] == b[MSB]) && (sum_x[MSB] != a[MSB]);
        sub_ovf = (a[MSB] != b[MSB]) && (dif_x[MSB] != a[MSB]);
    end

    // Select result, write/update controls and next flags per operation.
    always_comb begin
        res       = '0;
        wr_res    = 1'b0;
        upd_flags = 1'b0;
        nxt       = '0;
        case (op)
            OP_ADD: begin
                res       = sum_x[MSB:0];
                wr_res    = 1'b1;
                upd_flags = 1'b1;
                nxt.c     = sum_x[W];
                nxt.z     = (sum_x[MSB:0] == '0);
                nxt.s     = sum_x[MSB];
                nxt.o     = add_ovf;
            end
            OP_SUB, OP_CMP: begin
                res       = dif_x[MSB:0];
                wr_res    = (op == OP_SUB);
                upd_flags = 1'b1;
                nxt.c     = dif_x[W];
                nxt.z     = (dif_x[MSB:0] == '0);
                nxt.s     = dif_x[MSB];
                nxt.o     = sub_ovf;
            end
            OP_TST: begin
                res       = and_v;
                upd_flags = 1'b1;
                nxt.z     = (and_v == '0);
                nxt.s     = and_v[MSB];
            end
            OP_LEA: begin
                res    = sum_x[MSB:0];
                wr_res = 1'b1;
            end
            default: begin
                res = '0;
            end
        endcase
    end

endmodule

// File: rtl/alu_flag_reg.sv
// Four-bit status register. Loads new flags when enabled.
// Assumes synchronous active-low reset clearing every flag.
module alu_flag_reg
    import alu_cond_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  flags_t d,
    output flags_t q
);
    // Hold or load flags on each rising edge; reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/alu_cond_eval.sv
// Evaluates a 4-bit condition code against stored flags and widens it
// into a zero-extended byte. Assumes unused codes mean "false".
module alu_cond_eval
    import alu_cond_pkg::*;
#(
    parameter int SET_W = 8
) (
    input  flags_t            f,
    input  logic [3:0]        code,
    output logic              hit,
    output logic [SET_W-1:0]  set_v
);
    logic lt_s;

    // Signed "less" term shared by four predicates.
    always_comb lt_s = f.s ^ f.o;

    // Decode the condition code.
    always_comb begin
        case (cond_e'(code))
            CC_ALWAYS: hit = 1'b1;
            CC_EQ:     hit = f.z;
            CC_NE:     hit = ~f.z;
            CC_NEG:    hit = f.s;
            CC_NNEG:   hit = ~f.s;
            CC_SGT:    hit = ~lt_s & ~f.z;
            CC_SGE:    hit = ~lt_s;
            CC_SLT:    hit = lt_s;
            CC_SLE:    hit = lt_s | f.z;
            CC_ABOVE:  hit = ~f.c & ~f.z;
            CC_BELOW:  hit = f.c;
            default:   hit = 1'b0;
        endcase
    end

    // Zero-extend the single condition bit to the output byte.
    always_comb set_v = {{(SET_W-1){1'b0}}, hit};

endmodule

// File: rtl/alu_cond_unit.sv
// Top: integer ALU + status register + condition evaluator.
// Assumes the result path is combinational and the flags are registered.
// The condition outputs follow the registered flags.
module alu_cond_unit
    import alu_cond_pkg::*;
#(
    parameter int W     = 32,
    parameter int SET_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [2:0]       op_sel,
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     opnd_b,
    output logic [W-1:0]     res_data,
    output logic             res_we,
    output logic [3:0]       flag_q,
    input  logic [3:0]       cond_sel,
    output logic             take_br,
    output logic [SET_W-1:0] set_byte
);
    logic   wr_raw;
    logic   upd_raw;
    flags_t nxt_f;
    flags_t cur_f;

    alu_arith #(.W(W)) u_arith (
        .op_code   (op_sel),
        .a         (opnd_a),
        .b         (opnd_b),
        .res       (res_data),
        .wr_res    (wr_raw),
        .upd_flags (upd_raw),
        .nxt       (nxt_f)
    );

    alu_flag_reg u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (op_valid & upd_raw),
        .d     (nxt_f),
        .q     (cur_f)
    );

    alu_cond_eval #(.SET_W(SET_W)) u_cond (
        .f     (cur_f),
        .code  (cond_sel),
        .hit   (take_br),
        .set_v (set_byte)
    );

    // Gate the write strobe and expose the stored flags.
    always_comb begin
        res_we = op_valid & wr_raw;
        flag_q = cur_f;
    end

endmodule

// File: rtl/alu_cond_chk.sv
// Assertion checker for alu_cond_unit, attached by bind below.
module alu_cond_chk #(
    parameter int W     = 32,
    parameter int SET_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [2:0]       op_sel,
    input logic [W-1:0]     opnd_a,
    input logic [W-1:0]     opnd_b,
    input logic [W-1:0]     res_data,
    input logic             res_we,
    input logic [3:0]       flag_q,
    input logic [3:0]       cond_sel,
    input logic             take_br,
    input logic [SET_W-1:0] set_byte
);
    a_r1_add_zero_sets_z: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 3'd0 && W'(opnd_a + opnd_b) == '0) |=> flag_q[2]);

    a_r5_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 3'd2) |-> !res_we);

    a_r5_cmp_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 3'd2 && res_data == '0) |=> flag_q[2]);

    a_r6_test_clears_co: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 3'd3) |=> (!flag_q[3] && !flag_q[0]));

    a_r7_lea_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 3'd4) |=> $stable(flag_q));

    a_r8_idle_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(flag_q));

    a_r8_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> !res_we);

    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (flag_q == 4'b0000));

    a_r11_always_true: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 4'd0) |-> take_br);

    a_r12_set_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (set_byte[SET_W-1:1] == '0) && (set_byte[0] == take_br));

endmodule

bind alu_cond_unit alu_cond_chk #(.W(W), .SET_W(SET_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_sel   (op_sel),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .res_data (res_data),
    .res_we   (res_we),
    .flag_q   (flag_q),
    .cond_sel (cond_sel),
    .take_br  (take_br),
    .set_byte (set_byte)
);

// File: tb/test_alu_cond_unit.sv
`timescale 1ns/100ps
module test_alu_cond_unit;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] r;
        logic        we;
        logic [3:0]  f;   // {C,Z,S,O} expected after the edge
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 1'b1, 4'b0000}, // R1
        '{3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1, 4'b1100}, // R1 R2
        '{3'd0, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b1, 4'b0011}, // R3
        '{3'd0, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 1'b1, 4'b1101}, // R3
        '{3'd1, 32'h0000_0005, 32'h0000_0003, 32'h0000_0002, 1'b1, 4'b0000}, // R4
        '{3'd1, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE, 1'b1, 4'b1010}, // R4
        '{3'd2, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 1'b0, 4'b0001}, // R5
        '{3'd2, 32'h0000_0007, 32'h0000_0007, 32'h0000_0000, 1'b0, 4'b0100}, // R5
        '{3'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000, 1'b0, 4'b1011}, // R5
        '{3'd3, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 32'h0000_0000, 1'b0, 4'b0100}, // R6
        '{3'd3, 32'h8000_0001, 32'h8000_0000, 32'h8000_0000, 1'b0, 4'b0010}, // R6
        '{3'd4, 32'h0000_0010, 32'h0000_0020, 32'h0000_0030, 1'b1, 4'b0010}, // R7
        '{3'd4, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1, 4'b0010}, // R7
        '{3'd5, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b0, 4'b0010}  // R8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] res_data;
    logic        res_we;
    logic [3:0]  flag_q;
    logic [3:0]  cond_sel = '0;
    logic        take_br;
    logic [7:0]  set_byte;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    alu_cond_unit i_alu_cond_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .res_data(res_data), .res_we(res_we),
        .flag_q(flag_q), .cond_sel(cond_sel), .take_br(take_br), .set_byte(set_byte)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected condition from R10/R11, flags given as {C,Z,S,O}.
    function automatic logic cond_ref(input logic [3:0] f, input int code);
        logic c, z, s, o;
        {c, z, s, o} = f;
        case (code)
            0:  return 1'b1;
            1:  return z;
            2:  return !z;
            3:  return s;
            4:  return !s;
            5:  return !(s ^ o) && !z;
            6:  return !(s ^ o);
            7:  return s ^ o;
            8:  return (s ^ o) || z;
            9:  return !c && !z;
            10: return c;
            default: return 1'b0;
        endcase
    endfunction

    task automatic sweep_conds(input logic [3:0] f);
        for (int k = 0; k < 16; k++) begin
            cond_sel = 4'(k);
            #1;
            check((k == 0 || k > 10) ? "R11 take_br" : "R10 take_br",
                  {31'b0, take_br}, {31'b0, cond_ref(f, k)});
            check("R12 set_byte", {24'b0, set_byte}, {31'b0, cond_ref(f, k)});
        end
    endtask

    initial begin
        #(100000 * 4);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL all requirements: watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 flags in reset", {28'b0, flag_q}, 32'h0);
        check("R8 no write when idle", {31'b0, res_we}, 32'h0);
        rst_n = 1'b1;

        // Table walk: drive, check result, then flags and all conditions.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_sel = VECS[i].op;
            opnd_a = VECS[i].a;
            opnd_b = VECS[i].b;
            op_valid = 1'b1;
            #1;
            check("R1/R4/R5/R6/R7/R8 res_we", {31'b0, res_we}, {31'b0, VECS[i].we});
            if (VECS[i].we) check("R1 R4 R7 result", res_data, VECS[i].r);
            @(negedge clk);
            op_valid = 1'b0;
            check("R2 R3 R4 R5 R6 R7 R8 flags", {28'b0, flag_q}, {28'b0, VECS[i].f});
            sweep_conds(VECS[i].f);
        end

        // R8: flag-setting operation with strobe low leaves flags alone.
        @(negedge clk);
        op_sel = 3'd0;
        opnd_a = 32'hFFFF_FFFF;
        opnd_b = 32'h0000_0001;
        op_valid = 1'b0;
        #1;
        check("R8 idle res_we", {31'b0, res_we}, 32'h0);
        @(negedge clk);
        @(negedge clk);
        check("R8 idle flags held", {28'b0, flag_q}, 32'h2);

        // Make all flags nonzero-ish, then R9 reset clears them.
        op_valid = 1'b1;
        op_sel = 3'd2;
        opnd_a = 32'h7FFF_FFFF;
        opnd_b = 32'hFFFF_FFFF;
        @(negedge clk);
        op_valid = 1'b0;
        check("R5 borrow flags", {28'b0, flag_q}, 32'hB);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R9 reset clears", {28'b0, flag_q}, 32'h0);
        sweep_conds(4'b0000);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule